// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block holds the on-chip scratch memory of a small 8-bit processor core. Its 256 bytes form two banks. The lower bank answers at addresses 00h to 7Fh. The upper bank shares the addresses 80h to FFh with a bus of special-function registers. The core presents one access per clock. Each access carries an address, separate read and write strobes, write data, a flag for pointer-based (indirect) addressing and a flag that marks stack traffic.

For an address in the upper half, the addressing style decides where the access goes. A direct access leaves the block on the register bus, and the memory is not touched. An indirect access, or any stack access, goes to the upper RAM bank. Addresses in the lower half reach the lower bank in either style. Read results come back one clock after the read strobe. A register-bus read comes back through the same output, one clock late.

Top module: `idata_mem`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `rdData` is 00h.
- R2: An access to an address from 00h to 7Fh reaches the lower bank in both addressing styles. A byte written in one style reads back in the other style, and the register bus stays idle.
- R3: A direct write to an address from 80h to FFh raises `sfrWr` in the same cycle, with `sfrAddr` equal to the address and `sfrWdata` equal to the write data. The upper RAM byte is left unchanged.
- R4: An indirect access (`accIndirect`=1) to an address from 80h to FFh reads or writes the upper RAM byte, and neither SFR strobe rises. For example, indirect A0h reaches RAM.
- R5: An access with `accStack`=1 is handled as indirect even when `accIndirect`=0. It never raises an SFR strobe.
- R6: A write to the upper RAM byte at some address, and a register-bus write to the same address, leave each other's contents unchanged.
- R7: Read data appears on `rdData` on the clock edge after the read strobe. For a direct read at 80h to FFh, `sfrRd` is raised in the strobe cycle, and `rdData` then carries the `sfrRdata` value sampled in that cycle.
- R8: `rdData` keeps its value in any cycle that has no read strobe, including write-only cycles.
- R9: When a read and a write to the same RAM byte share one cycle, the read returns the contents from before the write. The new value is visible to the next read.
- R10: All 256 RAM bytes are separate storage. Distinct values written to every address read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| accAddr | input | ADDR_W | Access address |
| accRd | input | 1 | Read strobe |
| accWr | input | 1 | Write strobe |
| accWdata | input | DATA_W | Write data |
| accIndirect | input | 1 | 1 = pointer-based (indirect) addressing |
| accStack | input | 1 | 1 = stack push or pop, handled as indirect |
| rdData | output | DATA_W | Registered read result |
| sfrAddr | output | ADDR_W | Register-bus address |
| sfrWr | output | 1 | Register-bus write strobe |
| sfrRd | output | 1 | Register-bus read strobe |
| sfrWdata | output | DATA_W | Register-bus write data |
| sfrRdata | input | DATA_W | Register-bus return data, valid in the `sfrRd` cycle |

## Verification
The bench builds the block with its default parameters: an 8-bit address and 8-bit data. With these values both 128-byte banks are small enough to sweep completely, and the 7Fh/80h boundary and FFh are real addresses. The bench models the register bus as a fixed function of its address. It then writes the upper RAM and the register bus at the same address in alternating styles, so any leak from one space into the other shows up as a wrong byte.

// File: rtl/idata_pkg.sv
package idata_pkg;
  // Routing strobes from the decoder to the storage datapath
  typedef struct packed {
    logic lowWr;
    logic highWr;
    logic lowRd;
    logic highRd;
    logic sfrWr;
    logic sfrRd;
  } routeStrb_t;
endpackage

// File: rtl/idata_route_ctrl.sv
module idata_route_ctrl
  import idata_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accRd,
  input  logic              accWr,
  input  logic              accIndirect,
  input  logic              accStack,
  output routeStrb_t        strb
);
  logic upperHalf;
  logic viaPointer;

  assign upperHalf  = accAddr[ADDR_W-1];
  assign viaPointer = accIndirect | accStack;

  always_comb begin
    strb        = '0;
    strb.lowWr  = accWr & ~upperHalf;
    strb.lowRd  = accRd & ~upperHalf;
    strb.highWr = accWr & upperHalf & viaPointer;
    strb.highRd = accRd & upperHalf & viaPointer;
    strb.sfrWr  = accWr & upperHalf & ~viaPointer;
    strb.sfrRd  = accRd & upperHalf & ~viaPointer;
  end

  // Stack traffic never leaves on the register bus
  p_stack_no_sfr_r5: assert property (@(posedge clk) disable iff (!rstN)
    accStack |-> !strb.sfrWr && !strb.sfrRd);

  // Lower half always lands in the lower bank
  p_low_half_local_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accWr && !accAddr[ADDR_W-1]) |-> (strb.lowWr && !strb.sfrWr && !strb.highWr));

  // Indirect upper accesses stay in RAM
  p_indirect_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accIndirect && accAddr[ADDR_W-1]) |-> !strb.sfrRd && !strb.sfrWr);
endmodule

// File: rtl/idata_store_path.sv
module idata_store_path
  import idata_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeStrb_t        strb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  input  logic [DATA_W-1:0] sfrRdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int HALF  = 1 << IDX_W;
  localparam int BANKS = 2;

  logic [IDX_W-1:0]  bankIdx;
  logic [DATA_W-1:0] bankQ [BANKS];
  logic [BANKS-1:0]  bankWe;

  assign bankIdx = accAddr[IDX_W-1:0];
  assign bankWe  = {strb.highWr, strb.lowWr};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [HALF];
    always_ff @(posedge clk) begin
      if (bankWe[b]) mem[bankIdx] <= accWdata;
    end
    assign bankQ[b] = mem[bankIdx];
  end

  // Registered read: sampled before any same-cycle write lands
  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.lowRd)  rdData <= bankQ[0];
    else if (strb.highRd) rdData <= bankQ[1];
    else if (strb.sfrRd)  rdData <= sfrRdata;
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.lowRd || strb.highRd || strb.sfrRd) |=> $stable(rdData));

  p_sfr_forward_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.sfrRd |=> rdData == $past(sfrRdata));
endmodule

// File: rtl/idata_mem.sv
module idata_mem
  import idata_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accRd,
  input  logic              accWr,
  input  logic [DATA_W-1:0] accWdata,
  input  logic              accIndirect,
  input  logic              accStack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sfrAddr,
  output logic              sfrWr,
  output logic              sfrRd,
  output logic [DATA_W-1:0] sfrWdata,
  input  logic [DATA_W-1:0] sfrRdata
);
  routeStrb_t strb;

  idata_route_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accRd(accRd), .accWr(accWr),
    .accIndirect(accIndirect), .accStack(accStack), .strb(strb)
  );

  idata_store_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .accAddr(accAddr),
    .accWdata(accWdata), .sfrRdata(sfrRdata), .rdData(rdData)
  );

  assign sfrAddr  = accAddr;
  assign sfrWdata = accWdata;
  assign sfrWr    = strb.sfrWr;
  assign sfrRd    = strb.sfrRd;

  // Register-bus writes come only from direct upper-half accesses
  p_sfr_direct_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    sfrWr |-> accAddr[ADDR_W-1] && !accIndirect && !accStack);
endmodule

// File: tb/idata_mem_tb.sv
module idata_mem_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] accAddr;
  logic       accRd, accWr, accIndirect, accStack;
  logic [7:0] accWdata;
  logic [7:0] rdData, sfrAddr, sfrWdata, sfrRdata;
  logic       sfrWr, sfrRd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       sawSfrWr, sawSfrRd;
  logic [7:0] sawSfrAddr, sawSfrWdata;

  always #5 clk = ~clk;

  // Register-bus model: return data is a fixed function of the address
  assign sfrRdata = sfrAddr ^ 8'h5A;

  idata_mem u_dut (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accRd(accRd), .accWr(accWr),
    .accWdata(accWdata), .accIndirect(accIndirect), .accStack(accStack),
    .rdData(rdData), .sfrAddr(sfrAddr), .sfrWr(sfrWr), .sfrRd(sfrRd),
    .sfrWdata(sfrWdata), .sfrRdata(sfrRdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Starts at a falling edge, ends at the next falling edge (rdData valid there)
  task automatic op(input logic [7:0] a, input logic rd, input logic wr,
                    input logic [7:0] wd, input logic ind, input logic stk);
    accAddr = a; accRd = rd; accWr = wr; accWdata = wd;
    accIndirect = ind; accStack = stk;
    #2;
    sawSfrWr = sfrWr; sawSfrRd = sfrRd; sawSfrAddr = sfrAddr; sawSfrWdata = sfrWdata;
    @(negedge clk);
    accRd = 1'b0; accWr = 1'b0; accIndirect = 1'b0; accStack = 1'b0;
  endtask

  task automatic t_reset;
    rstN = 1'b0; accAddr = '0; accRd = 0; accWr = 0; accWdata = '0;
    accIndirect = 0; accStack = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdData in reset", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData after release", rdData, 8'h00);
  endtask

  task automatic t_lower;
    op(8'h10, 0, 1, 8'h11, 0, 0);
    chk("R2 no sfrWr low direct", {7'd0, sawSfrWr}, 8'h00);
    op(8'h10, 1, 0, 8'h00, 1, 0);
    chk("R2 R7 indirect read of direct write", rdData, 8'h11);
    op(8'h7F, 0, 1, 8'hE7, 1, 0);
    op(8'h7F, 1, 0, 8'h00, 0, 0);
    chk("R2 direct read 7Fh", rdData, 8'hE7);
    chk("R2 no sfrRd at 7Fh", {7'd0, sawSfrRd}, 8'h00);
  endtask

  task automatic t_upper_indirect;
    op(8'hA0, 0, 1, 8'hC3, 1, 0);
    chk("R4 no sfrWr indirect A0", {7'd0, sawSfrWr}, 8'h00);
    op(8'hA0, 1, 0, 8'h00, 1, 0);
    chk("R4 indirect read A0", rdData, 8'hC3);
    chk("R4 no sfrRd indirect A0", {7'd0, sawSfrRd}, 8'h00);
  endtask

  task automatic t_direct_sfr;
    op(8'hA0, 0, 1, 8'h3C, 0, 0);
    chk("R3 sfrWr raised", {7'd0, sawSfrWr}, 8'h01);
    chk("R3 sfrAddr", sawSfrAddr, 8'hA0);
    chk("R3 sfrWdata", sawSfrWdata, 8'h3C);
    op(8'hA0, 1, 0, 8'h00, 1, 0);
    chk("R3 R6 upper RAM kept after bus write", rdData, 8'hC3);
    op(8'hA0, 1, 0, 8'h00, 0, 0);
    chk("R7 sfrRd raised", {7'd0, sawSfrRd}, 8'h01);
    chk("R7 R6 bus read data forwarded", rdData, 8'hA0 ^ 8'h5A);
    op(8'hFF, 1, 0, 8'h00, 0, 0);
    chk("R7 bus read FFh", rdData, 8'hFF ^ 8'h5A);
  endtask

  task automatic t_stack;
    op(8'h90, 0, 1, 8'h77, 0, 1);
    chk("R5 stack write no sfrWr", {7'd0, sawSfrWr}, 8'h00);
    op(8'h90, 1, 0, 8'h00, 1, 0);
    chk("R5 stack byte in upper RAM", rdData, 8'h77);
    op(8'h80, 0, 1, 8'h81, 0, 1);
    op(8'h80, 1, 0, 8'h00, 0, 1);
    chk("R5 stack pop 80h", rdData, 8'h81);
    chk("R5 stack read no sfrRd", {7'd0, sawSfrRd}, 8'h00);
  endtask

  task automatic t_hold;
    op(8'h10, 1, 0, 8'h00, 0, 0);
    op(8'h00, 0, 0, 8'h00, 0, 0);
    chk("R8 idle keeps rdData", rdData, 8'h11);
    op(8'h10, 0, 1, 8'h99, 0, 0);
    chk("R8 write-only keeps rdData", rdData, 8'h11);
    op(8'hB0, 0, 1, 8'h55, 0, 0);
    chk("R8 bus write keeps rdData", rdData, 8'h11);
  endtask

  task automatic t_rw_same;
    op(8'h20, 0, 1, 8'h01, 1, 0);
    op(8'h20, 1, 1, 8'h02, 1, 0);
    chk("R9 same-cycle read returns old low", rdData, 8'h01);
    op(8'h20, 1, 0, 8'h00, 1, 0);
    chk("R9 new value visible low", rdData, 8'h02);
    op(8'hC8, 0, 1, 8'h0A, 1, 0);
    op(8'hC8, 1, 1, 8'h0B, 1, 0);
    chk("R9 same-cycle read returns old high", rdData, 8'h0A);
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 256; a++) op(a[7:0], 0, 1, a[7:0] ^ 8'hA5, 1, 0);
    for (int a = 128; a < 256; a++) op(a[7:0], 0, 1, ~a[7:0], 0, 0);
    for (int a = 0; a < 256; a++) begin
      op(a[7:0], 1, 0, 8'h00, 1, 0);
      chk("R10 R6 sweep readback", rdData, a[7:0] ^ 8'hA5);
    end
  endtask

  initial begin
    t_reset();
    t_lower();
    t_upper_indirect();
    t_direct_sfr();
    t_stack();
    t_hold();
    t_rw_same();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule